// File: doc/BRIEF.md
# Three-Port Cell Transmit Ingress

This block is the physical-layer side of an 8-bit cell transmit bus that is shared by three ports. A layer device drives one byte-wide data bus, a start-of-cell strobe and an odd-parity bit. It selects the target port by pulling that port's active-low enable. The block tells the device which ports have room for another full 53-byte cell. It gathers the bytes of each port into a frame. A frame becomes visible in that port's FIFO only once all 53 bytes have arrived.

Parity is checked on every byte the block accepts. An error is only recorded, and the byte is stored anyway. Each port has a sticky error flag that is armed by its own enable bit and cleared by a write-one strobe. Downstream logic empties each FIFO one byte at a time through a simple pop interface.

Top module: `cell_tx_ingress`

## Requirements
- R1: A byte is accepted only on a rising clock edge where exactly one bit of `tx_en_n` is 0. The port it goes to is that bit's index. With no bit low, or with two or more bits low, the bus is ignored.
- R2: `tx_clav[p]` is 1 exactly when 106 minus (committed bytes plus bytes of the frame in progress) is at least 53. It reflects an accepted byte or a pop from the next cycle on.
- R3: An accepted byte with `tx_soc`=1 opens a frame. When the frame's 53rd byte is accepted, the whole frame is committed. From the following cycle its bytes appear at `rd_data[p*8 +: 8]` in arrival order, with `rd_valid[p]`=1.
- R4: An accepted byte with `tx_soc`=0 on a port that has no open frame is discarded.
- R5: A `tx_soc` byte on a port whose frame is still open discards the partial frame. The new byte becomes byte 1 of a new frame.
- R6: A byte has a parity error when the XOR of `tx_data` and `tx_par` is 0. An error on port p sets `perr_flag[p]` on the next cycle only if `perr_en[p]` is 1.
- R7: A byte with a parity error is stored and delivered like any other byte.
- R8: `perr_flag[p]` stays set until a cycle with `perr_clr[p]`=1. If a new enabled error arrives in that same cycle, the flag stays set.
- R9: If a `tx_soc` byte arrives while the port's committed occupancy exceeds 53, the whole frame is refused. None of its bytes are stored.
- R10: `rd_en[p]` removes one byte when `rd_valid[p]`=1. It has no effect on an empty FIFO.
- R11: After reset every `tx_clav` bit is 1, and every `rd_valid` and `perr_flag` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en_n | input | 3 | Per-port write enable, active low |
| tx_soc | input | 1 | Start of cell, high with the first byte |
| tx_data | input | 8 | Shared transmit data byte |
| tx_par | input | 1 | Odd parity over tx_data |
| tx_clav | output | 3 | Per-port room for one full cell |
| perr_en | input | 3 | Per-port parity error logging enable |
| perr_clr | input | 3 | Per-port write-one-to-clear strobe |
| perr_flag | output | 3 | Sticky per-port parity error flags |
| rd_en | input | 3 | Per-port pop request |
| rd_data | output | 24 | Head byte of each FIFO, port p in bits p*8+7:p*8 |
| rd_valid | output | 3 | Per-port FIFO holds committed data |

## Verification
The hardest state to reach is the refusal case of R9. The layer device would normally obey `tx_clav`, so a port only reaches more than 53 committed bytes when two full frames are written with no draining. The bench then deliberately ignores the low `tx_clav` and sends a third frame. It pops a single byte, so occupancy sits at 105, and sends a fourth frame. Only after draining a further 53 bytes does it send a frame that must be taken. At each step a behavioural queue model is compared against the outputs on every clock.

// File: rtl/cti_pkg.sv
package cti_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] cti_byte_t;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_FILL = 1'b1
    } cti_frame_e;

    typedef struct packed {
        cti_byte_t data;
        logic      soc;
    } cti_beat_t;

    // 1 when data plus parity bit hold an odd number of ones
    function automatic logic odd_ok(input cti_byte_t d, input logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/cti_port_sel.sv
module cti_port_sel #(
    parameter int NPORTS = 3
) (
    input  logic [NPORTS-1:0] en_n,
    output logic [NPORTS-1:0] port_wr
);
    int lows;

    always_comb begin
        lows = 0;
        for (int i = 0; i < NPORTS; i++) begin
            lows = lows + (en_n[i] ? 0 : 1);
        end
        port_wr = (lows == 1) ? ~en_n : '0;
    end

    always_comb begin
        a_r1_single_target: assert ($onehot0(port_wr));
    end

endmodule

// File: rtl/cti_err_status.sv
module cti_err_status #(
    parameter int NPORTS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] hit,
    input  logic [NPORTS-1:0] en,
    input  logic [NPORTS-1:0] clr,
    output logic [NPORTS-1:0] flag
);
    for (genvar i = 0; i < NPORTS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                flag[i] <= 1'b0;
            end else if (hit[i] && en[i]) begin
                flag[i] <= 1'b1;      // a new error beats a clear
            end else if (clr[i]) begin
                flag[i] <= 1'b0;
            end
        end

        a_r6_flag_needs_en: assert property (@(posedge clk) disable iff (rst)
            $rose(flag[i]) |-> $past(hit[i] && en[i]));

        a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !(hit[i] && en[i])) |=> !flag[i]);
    end

endmodule

// File: rtl/cti_cell_fifo.sv
module cti_cell_fifo
    import cti_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int CELL_SLOTS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  cti_beat_t beat,
    input  logic      rd_en,
    output cti_byte_t rd_data,
    output logic      rd_valid,
    output logic      clav
);
    localparam int DEPTH = CELL_BYTES * CELL_SLOTS;
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int FRM_W = $clog2(CELL_BYTES + 1);
    localparam logic [CNT_W-1:0] CELL_C  = CNT_W'(CELL_BYTES);
    localparam logic [CNT_W-1:0] ROOM_C  = CNT_W'(DEPTH - CELL_BYTES);
    localparam logic [FRM_W-1:0] LAST_C  = FRM_W'(CELL_BYTES - 1);

    cti_byte_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, cm_ptr, rd_ptr, wr_slot;
    logic [CNT_W-1:0] cnt_cm;
    logic [FRM_W-1:0] frm_cnt;
    cti_frame_e       state;
    logic             pop, start, refuse, cont, last, do_write;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop      = rd_en && (cnt_cm != '0);
        start    = wr_en && beat.soc && (cnt_cm <= ROOM_C);
        refuse   = wr_en && beat.soc && (cnt_cm >  ROOM_C);
        cont     = wr_en && !beat.soc && (state == FR_FILL);
        last     = cont && (frm_cnt == LAST_C);
        wr_slot  = start ? cm_ptr : wr_ptr;
        do_write = start || cont;
    end

    always_ff @(posedge clk) begin
        if (do_write) begin
            mem[wr_slot] <= beat.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            cm_ptr  <= '0;
            rd_ptr  <= '0;
            cnt_cm  <= '0;
            frm_cnt <= '0;
            state   <= FR_IDLE;
        end else begin
            if (start) begin
                wr_ptr  <= bump(cm_ptr);
                frm_cnt <= FRM_W'(1);
                state   <= FR_FILL;
            end else if (refuse) begin
                wr_ptr  <= cm_ptr;
                frm_cnt <= '0;
                state   <= FR_IDLE;
            end else if (cont) begin
                wr_ptr <= bump(wr_ptr);
                if (last) begin
                    cm_ptr  <= bump(wr_ptr);
                    frm_cnt <= '0;
                    state   <= FR_IDLE;
                end else begin
                    frm_cnt <= frm_cnt + 1'b1;
                end
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            cnt_cm <= cnt_cm + (last ? CELL_C : '0) - (pop ? CNT_W'(1) : '0);
        end
    end

    assign rd_data  = mem[rd_ptr];
    assign rd_valid = (cnt_cm != '0);
    assign clav     = (DEPTH - int'(cnt_cm) - int'(frm_cnt)) >= CELL_BYTES;

    a_r2_occupancy_bound: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt_cm) + int'(frm_cnt)) <= DEPTH);

    a_r3_commit_visible: assert property (@(posedge clk) disable iff (rst)
        last |=> rd_valid);

    a_r9_refuse_no_growth: assert property (@(posedge clk) disable iff (rst)
        refuse |=> (cnt_cm <= $past(cnt_cm)) && (frm_cnt == '0));

    a_r10_empty_pop_inert: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_valid) |=> $stable(rd_ptr));

endmodule

// File: rtl/cell_tx_ingress.sv
module cell_tx_ingress
    import cti_pkg::*;
#(
    parameter int NPORTS     = 3,
    parameter int CELL_BYTES = 53,
    parameter int CELL_SLOTS = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NPORTS-1:0]          tx_en_n,
    input  logic                       tx_soc,
    input  logic [BYTE_W-1:0]          tx_data,
    input  logic                       tx_par,
    output logic [NPORTS-1:0]          tx_clav,
    input  logic [NPORTS-1:0]          perr_en,
    input  logic [NPORTS-1:0]          perr_clr,
    output logic [NPORTS-1:0]          perr_flag,
    input  logic [NPORTS-1:0]          rd_en,
    output logic [NPORTS*BYTE_W-1:0]   rd_data,
    output logic [NPORTS-1:0]          rd_valid
);
    logic [NPORTS-1:0] port_wr;
    logic [NPORTS-1:0] err_hit;
    cti_beat_t         beat;

    assign beat.data = tx_data;
    assign beat.soc  = tx_soc;

    cti_port_sel #(.NPORTS(NPORTS)) u_sel (
        .en_n    (tx_en_n),
        .port_wr (port_wr)
    );

    assign err_hit = odd_ok(tx_data, tx_par) ? '0 : port_wr;

    cti_err_status #(.NPORTS(NPORTS)) u_err (
        .clk  (clk),
        .rst  (rst),
        .hit  (err_hit),
        .en   (perr_en),
        .clr  (perr_clr),
        .flag (perr_flag)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        cti_cell_fifo #(
            .CELL_BYTES (CELL_BYTES),
            .CELL_SLOTS (CELL_SLOTS)
        ) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (port_wr[p]),
            .beat     (beat),
            .rd_en    (rd_en[p]),
            .rd_data  (rd_data[p*BYTE_W +: BYTE_W]),
            .rd_valid (rd_valid[p]),
            .clav     (tx_clav[p])
        );
    end

    a_r11_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (perr_flag == '0) && (rd_valid == '0));

endmodule

// File: tb/tb_cell_tx_ingress.sv
module tb_cell_tx_ingress;
    localparam int NP    = 3;
    localparam int CELL  = 53;
    localparam int DEPTH = 106;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] tx_en_n = '1;
    logic          tx_soc = 1'b0;
    logic [7:0]    tx_data = '0;
    logic          tx_par = 1'b0;
    logic [NP-1:0] tx_clav;
    logic [NP-1:0] perr_en = '0;
    logic [NP-1:0] perr_clr = '0;
    logic [NP-1:0] perr_flag;
    logic [NP-1:0] rd_en = '0;
    logic [NP*8-1:0] rd_data;
    logic [NP-1:0] rd_valid;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    cell_tx_ingress dut (
        .clk(clk), .rst(rst), .tx_en_n(tx_en_n), .tx_soc(tx_soc),
        .tx_data(tx_data), .tx_par(tx_par), .tx_clav(tx_clav),
        .perr_en(perr_en), .perr_clr(perr_clr), .perr_flag(perr_flag),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // behavioural reference model
    int q_cm   [NP][$];
    int q_part [NP][$];
    bit m_open [NP];
    bit m_flag [NP];

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NP; p++) begin
                q_cm[p].delete(); q_part[p].delete();
                m_open[p] = 0; m_flag[p] = 0;
            end
        end else begin
            int lows; int tgt; bit bad; bit room; bit [NP-1:0] popq;
            lows = 0; tgt = -1;
            for (int p = 0; p < NP; p++) if (!tx_en_n[p]) begin lows++; tgt = p; end
            bad = ((^tx_data) ^ tx_par) == 1'b0;
            for (int p = 0; p < NP; p++) popq[p] = rd_en[p] && (q_cm[p].size() > 0);
            room = (tgt >= 0) ? (q_cm[tgt].size() <= DEPTH - CELL) : 0;
            for (int p = 0; p < NP; p++) if (popq[p]) void'(q_cm[p].pop_front());
            for (int p = 0; p < NP; p++) begin
                bit set;
                set = (lows == 1) && (tgt == p) && bad && perr_en[p];
                if (set) m_flag[p] = 1;
                else if (perr_clr[p]) m_flag[p] = 0;
            end
            if (lows == 1) begin
                if (tx_soc) begin
                    q_part[tgt].delete();
                    if (room) begin q_part[tgt].push_back(tx_data); m_open[tgt] = 1; end
                    else m_open[tgt] = 0;
                end else if (m_open[tgt]) begin
                    q_part[tgt].push_back(tx_data);
                    if (q_part[tgt].size() == CELL) begin
                        foreach (q_part[tgt][i]) q_cm[tgt].push_back(q_part[tgt][i]);
                        q_part[tgt].delete();
                        m_open[tgt] = 0;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int p = 0; p < NP; p++) begin
                bit ec; int used;
                used = q_cm[p].size() + q_part[p].size();
                ec = (DEPTH - used) >= CELL;
                chk(tx_clav[p] == ec, "R2 clav", tx_clav[p], ec);
                chk(rd_valid[p] == (q_cm[p].size() > 0), "R3 rd_valid", rd_valid[p], q_cm[p].size() > 0);
                if (q_cm[p].size() > 0)
                    chk(rd_data[p*8 +: 8] == q_cm[p][0], "R3/R7 rd_data", rd_data[p*8 +: 8], q_cm[p][0]);
                chk(perr_flag[p] == m_flag[p], "R6/R8 flag", perr_flag[p], m_flag[p]);
            end
        end
    end

    task automatic put(input logic [NP-1:0] en_n, input bit soc, input logic [7:0] d, input bit good);
        @(negedge clk);
        tx_en_n = en_n; tx_soc = soc; tx_data = d;
        tx_par  = good ? ~^d : ^d;
    endtask

    task automatic idle();
        @(negedge clk);
        tx_en_n = '1; tx_soc = 0; perr_clr = '0;
    endtask

    task automatic send_cell(input int p, input logic [7:0] base, input int bad_at, input int len);
        for (int i = 0; i < len; i++)
            put(~(3'b1 << p), i == 0, base + 8'(i), i != bad_at);
    endtask

    task automatic drain(input int p, input int n);
        @(negedge clk); rd_en[p] = 1;
        repeat (n) @(negedge clk);
        rd_en[p] = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state, sampled while reset is held
        chk(tx_clav == 3'b111, "R11 clav", tx_clav, 7);
        chk(rd_valid == 3'b000, "R11 rd_valid", rd_valid, 0);
        chk(perr_flag == 3'b000, "R11 flag", perr_flag, 0);
        rst = 0;
        idle();

        // R3 one cell into port 0, then drained in order
        send_cell(0, 8'h10, -1, CELL); idle();
        chk(rd_valid[0] == 1, "R3 committed", rd_valid[0], 1);
        chk(rd_data[7:0] == 8'h10, "R3 first byte", rd_data[7:0], 8'h10);
        drain(0, CELL); idle();

        // R1 no enable low, then two enables low
        put(3'b111, 1, 8'hA0, 1);
        put(3'b100, 1, 8'hA1, 1);
        for (int i = 1; i < CELL; i++) put(3'b100, 0, 8'(i), 1);
        idle();
        chk(rd_valid == 3'b000, "R1 ignored", rd_valid, 0);

        // R4 stray bytes before a frame on port 2
        for (int i = 0; i < 5; i++) put(3'b011, 0, 8'hE0, 1);
        send_cell(2, 8'h40, -1, CELL); idle();
        chk(rd_data[23:16] == 8'h40, "R4 stray dropped", rd_data[23:16], 8'h40);
        drain(2, CELL); idle();

        // R5 abort after 20 bytes on port 1
        send_cell(1, 8'h70, -1, 20);
        send_cell(1, 8'h90, -1, CELL); idle();
        chk(rd_data[15:8] == 8'h90, "R5 restart", rd_data[15:8], 8'h90);
        drain(1, CELL); idle();

        // R6 R7 parity: logged on port 0, not logged on port 1
        perr_en = 3'b001;
        send_cell(0, 8'h20, 5, CELL); idle();
        chk(perr_flag[0] == 1, "R6 flag set", perr_flag[0], 1);
        send_cell(1, 8'h30, 7, CELL); idle();
        chk(perr_flag[1] == 0, "R6 disabled", perr_flag[1], 0);
        drain(0, 6); idle();
        chk(rd_data[7:0] == 8'h26, "R7 stored", rd_data[7:0], 8'h26);
        // R8 clear plus simultaneous error keeps flag, then plain clear
        send_cell(0, 8'h50, 0, 1); perr_clr = 3'b001; idle();
        chk(perr_flag[0] == 1, "R8 set wins", perr_flag[0], 1);
        @(negedge clk); perr_clr = 3'b001; idle();
        chk(perr_flag[0] == 0, "R8 cleared", perr_flag[0], 0);
        drain(0, CELL - 6); drain(1, CELL); idle();

        // R2 R9 fill port 1, ignore clav, refused frames
        send_cell(1, 8'h01, -1, CELL);
        send_cell(1, 8'h81, -1, 1); idle();
        chk(tx_clav[1] == 0, "R2 clav low", tx_clav[1], 0);
        send_cell(1, 8'h81, -1, CELL); idle();
        send_cell(1, 8'hC1, -1, CELL); idle();
        chk(rd_data[15:8] == 8'h01, "R9 head kept", rd_data[15:8], 8'h01);
        drain(1, 1);
        send_cell(1, 8'hC1, -1, CELL); idle();
        drain(1, CELL);
        send_cell(1, 8'hD0, -1, CELL); idle();
        chk(rd_valid[1] == 1, "R9 accepts again", rd_valid[1], 1);
        drain(1, 2 * CELL + 4); idle();

        // R10 pop on empty has no effect
        drain(2, 4); idle();
        chk(rd_valid[2] == 0, "R10 empty", rd_valid[2], 0);
        send_cell(2, 8'h33, -1, CELL); idle();
        chk(rd_data[23:16] == 8'h33, "R10 head intact", rd_data[23:16], 8'h33);

        // all three ports with overlapping drains
        send_cell(0, 8'h60, -1, CELL);
        @(negedge clk); rd_en = 3'b100;
        send_cell(1, 8'h61, -1, CELL);
        rd_en = 3'b000;
        idle();
        drain(0, CELL); drain(1, CELL); drain(2, CELL); idle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule